// File: doc/BRIEF.md
# SD Host Command and Status Unit

This unit is the memory-mapped command front end of an SD card host. Software loads an argument register and then writes a command word. When that word has its start bit set, the unit runs one transaction on a simple byte-level card interface. It sends a one-cycle request that carries the 6-bit command index and the argument, then waits as many cycles as the card needs for a response handshake. The card returns 0, 4 or 16 response bytes and an error indication.

When the response arrives, the unit checks its length against the command flags. A good response is packed into four 32-bit response words. A bad one, or a card error, marks the command as failed and sets a command-timeout status flag. Three event inputs from the host's data path set the busy, block and data status bits. Software clears a status bit by writing 1 to it. A single level interrupt is high while any of the three event bits is set.

The controller has three states. `IDLE` goes to `ISSUE` when a start command is written. `ISSUE` lasts one cycle, drives the request and always moves to `WAIT`. `WAIT` goes back to `IDLE` on the cycle the response is valid, and that cycle commits the result.

Top module: `sdh_cmd_unit`

## Requirements
- R1: After reset the command, argument, response and status registers all read 0, `irq` is low and `card_req` is low.
- R2: A write to offset 0x00 stores `wdata[15:0]`. Bit 15 set starts a transaction: on the following cycle `card_req` is high for exactly one cycle, with `card_idx` equal to bits 5:0 and `card_arg` equal to the argument register. Bit 15 reads back 1 until the response is accepted and 0 afterwards.
- R3: A write to offset 0x00 while a transaction is in flight has no effect.
- R4: A 4-byte response (`card_rsp_len`=4), where byte n is `card_rsp_data[8n+7:8n]`, is stored in response word 0 (offset 0x10) as {byte0,byte1,byte2,byte3}, and words 1 to 3 (0x14, 0x18, 0x1C) are cleared.
- R5: When a long response is requested (command bit 9), a 16-byte response is stored as word0={b12,b13,b14,b15}, word1={b8..b11}, word2={b4..b7} and word3={b0..b3}.
- R6: The command fails when `card_rsp_err` is high, or when a response is expected (bit 10 clear) and the length is 0, is 4 with bit 9 set, or is neither 4 nor 16. On failure command bit 14 and status bit 6 (0x040) are set, and the response words keep their values.
- R7: With command bit 10 (no response) set, the length is not checked and the response words keep their values. A card error still fails the command.
- R8: A write to the status register (offset 0x20) clears each bit that is 1 in `wdata[10:0]`. `ev_set[0]`, `ev_set[1]` and `ev_set[2]` set status bits 8, 9 and 10. A set in the same cycle as a clear wins.
- R9: `irq` is high exactly while any of status bits 10, 9 or 8 is set. Status bit 6 does not raise it.
- R10: A read of any offset other than 0x00, 0x04, 0x10 to 0x1C and 0x20 returns 0, and a write to such an offset changes nothing.
- R11: The argument register at offset 0x04 stores and returns all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational, no side effects) |
| ev_set | input | 3 | Event pulses that set status bits 8, 9, 10 |
| irq | output | 1 | Level interrupt |
| card_req | output | 1 | One-cycle command request to the card |
| card_idx | output | 6 | Command index |
| card_arg | output | 32 | Command argument |
| card_rsp_valid | input | 1 | Response handshake from the card |
| card_rsp_len | input | 5 | Response length in bytes |
| card_rsp_err | input | 1 | Card-reported error |
| card_rsp_data | input | 128 | Response bytes, byte n at bits 8n+7:8n |

## Verification
A state machine stuck in `WAIT` or `ISSUE` shows as command bit 15 staying set and later command writes being dropped. A spurious return to `ISSUE` shows as a second request pulse on the very next cycle. A wrong packing index or length decision appears in the response words one cycle after the handshake, and a missed fail in bit 14 and status bit 6 in that same cycle. Status bookkeeping errors reach `irq` one cycle after the write or event that caused them.

// File: rtl/sdh_pkg.sv
package sdh_pkg;
    localparam int OFF_CMD  = 'h00;
    localparam int OFF_ARG  = 'h04;
    localparam int OFF_RSP  = 'h10;
    localparam int OFF_STAT = 'h20;

    localparam int CMD_W    = 16;
    localparam int STAT_W   = 11;

    localparam int B_START  = 15;
    localparam int B_FAIL   = 14;
    localparam int B_NORSP  = 10;
    localparam int B_LONG   = 9;

    localparam int S_TMO    = 6;
    localparam int S_EV_LO  = 8;
    localparam int N_EV     = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } cmd_state_e;
endpackage

// File: rtl/sdh_cmd_fsm.sv
module sdh_cmd_fsm
    import sdh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic rsp_valid,
    output logic card_req,
    output logic busy,
    output logic commit
);
    cmd_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        card_req = 1'b0;
        busy     = 1'b1;
        commit   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                if (start) state_d = ST_ISSUE;
            end
            ST_ISSUE: begin
                card_req = 1'b1;
                state_d  = ST_WAIT;
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    commit  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/sdh_rsp_pack.sv
module sdh_rsp_pack #(
    parameter int RSP_WORDS = 4,
    parameter int LEN_W     = 5
) (
    input  logic                      no_rsp,
    input  logic                      long_req,
    input  logic                      rsp_err,
    input  logic [LEN_W-1:0]          rsp_len,
    input  logic [RSP_WORDS*32-1:0]   rsp_data,
    output logic                      fail,
    output logic [RSP_WORDS-1:0][31:0] words
);
    localparam int RSP_BYTES = RSP_WORDS * 4;
    localparam logic [LEN_W-1:0] LEN_SHORT = LEN_W'(4);
    localparam logic [LEN_W-1:0] LEN_LONG  = LEN_W'(RSP_BYTES);

    logic is_short;
    logic len_bad;

    assign is_short = (rsp_len == LEN_SHORT);
    assign len_bad  = (rsp_len == '0) || (is_short && long_req) ||
                      (!is_short && rsp_len != LEN_LONG);
    assign fail     = rsp_err || (!no_rsp && len_bad);

    for (genvar w = 0; w < RSP_WORDS; w++) begin : g_word
        localparam int LB = (RSP_WORDS - 1 - w) * 4;
        logic [31:0] long_w;
        logic [31:0] short_w;
        assign long_w = {rsp_data[8*LB +: 8], rsp_data[8*(LB+1) +: 8],
                         rsp_data[8*(LB+2) +: 8], rsp_data[8*(LB+3) +: 8]};
        if (w == 0) begin : g_first
            assign short_w = {rsp_data[7:0], rsp_data[15:8],
                              rsp_data[23:16], rsp_data[31:24]};
        end else begin : g_rest
            assign short_w = '0;
        end
        assign words[w] = is_short ? short_w : long_w;
    end
endmodule

// File: rtl/sdh_cmd_unit.sv
module sdh_cmd_unit
    import sdh_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int RSP_WORDS = 4,
    parameter int LEN_W     = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [31:0]             wdata,
    output logic [31:0]             rdata,
    input  logic [N_EV-1:0]         ev_set,
    output logic                    irq,
    output logic                    card_req,
    output logic [5:0]              card_idx,
    output logic [31:0]             card_arg,
    input  logic                    card_rsp_valid,
    input  logic [LEN_W-1:0]        card_rsp_len,
    input  logic                    card_rsp_err,
    input  logic [RSP_WORDS*32-1:0] card_rsp_data
);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFF_CMD);
    localparam logic [ADDR_W-1:0] A_ARG  = ADDR_W'(OFF_ARG);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);

    logic [CMD_W-1:0]              cmd_q;
    logic [31:0]                   arg_q;
    logic [STAT_W-1:0]             stat_q;
    logic [RSP_WORDS-1:0][31:0]    rsp_q;
    logic [RSP_WORDS-1:0][31:0]    packed_w;

    logic busy, commit, start, fail;
    logic wr_cmd, wr_stat;
    logic [STAT_W-1:0] stat_set, stat_clr;

    assign wr_cmd  = wr_en && (addr == A_CMD);
    assign wr_stat = wr_en && (addr == A_STAT);
    assign start   = wr_cmd && !busy && wdata[B_START];

    sdh_cmd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .rsp_valid (card_rsp_valid),
        .card_req  (card_req),
        .busy      (busy),
        .commit    (commit)
    );

    sdh_rsp_pack #(.RSP_WORDS(RSP_WORDS), .LEN_W(LEN_W)) u_pack (
        .no_rsp   (cmd_q[B_NORSP]),
        .long_req (cmd_q[B_LONG]),
        .rsp_err  (card_rsp_err),
        .rsp_len  (card_rsp_len),
        .rsp_data (card_rsp_data),
        .fail     (fail),
        .words    (packed_w)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (wr_cmd && !busy) begin
            cmd_q <= wdata[CMD_W-1:0];
        end else if (commit) begin
            cmd_q[B_START] <= 1'b0;
            if (fail) cmd_q[B_FAIL] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                      arg_q <= '0;
        else if (wr_en && addr == A_ARG) arg_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                                   rsp_q <= '0;
        else if (commit && !fail && !cmd_q[B_NORSP])  rsp_q <= packed_w;
    end

    always_comb begin
        stat_set = '0;
        stat_set[S_EV_LO +: N_EV] = ev_set;
        stat_set[S_TMO] = commit && fail;
        stat_clr = wr_stat ? wdata[STAT_W-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~stat_clr) | stat_set;
    end

    assign irq      = |stat_q[S_EV_LO +: N_EV];
    assign card_idx = cmd_q[5:0];
    assign card_arg = arg_q;

    always_comb begin
        rdata = '0;
        if (addr == A_CMD)  rdata = 32'(cmd_q);
        if (addr == A_ARG)  rdata = arg_q;
        if (addr == A_STAT) rdata = 32'(stat_q);
        for (int w = 0; w < RSP_WORDS; w++) begin
            if (addr == ADDR_W'(OFF_RSP + 4 * w)) rdata = rsp_q[w];
        end
    end
endmodule

// File: rtl/sdh_cmd_unit_chk.sv
module sdh_cmd_unit_chk
    import sdh_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int RSP_WORDS = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic [ADDR_W-1:0]        addr,
    input logic [31:0]              wdata,
    input logic [N_EV-1:0]          ev_set,
    input logic                     irq,
    input logic                     card_req,
    input logic                     card_rsp_err,
    input logic                     busy,
    input logic                     commit,
    input logic [CMD_W-1:0]         cmd_q,
    input logic [STAT_W-1:0]        stat_q,
    input logic [RSP_WORDS-1:0][31:0] rsp_q
);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFF_CMD);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);

    assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        card_req |=> !card_req);

    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !cmd_q[B_START]);

    assert_busy_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !commit && wr_en && addr == A_CMD) |=> cmd_q == $past(cmd_q));

    assert_err_marks_fail_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && card_rsp_err) |=> (cmd_q[B_FAIL] && stat_q[S_TMO]));

    assert_err_keeps_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && card_rsp_err) |=> rsp_q == $past(rsp_q));

    assert_norsp_keeps_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && cmd_q[B_NORSP]) |=> rsp_q == $past(rsp_q));

    assert_full_clear_drops_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_STAT && wdata[10:8] == 3'b111 && ev_set == '0) |=> !irq);

    assert_irq_needs_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ev_set) != '0);
endmodule

bind sdh_cmd_unit sdh_cmd_unit_chk #(.ADDR_W(ADDR_W), .RSP_WORDS(RSP_WORDS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .addr         (addr),
    .wdata        (wdata),
    .ev_set       (ev_set),
    .irq          (irq),
    .card_req     (card_req),
    .card_rsp_err (card_rsp_err),
    .busy         (busy),
    .commit       (commit),
    .cmd_q        (cmd_q),
    .stat_q       (stat_q),
    .rsp_q        (rsp_q)
);

// File: tb/sdh_cmd_unit_test.sv
`timescale 1ns/1ps
module sdh_cmd_unit_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [7:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic [2:0]   ev_set = '0;
    logic         irq;
    logic         card_req;
    logic [5:0]   card_idx;
    logic [31:0]  card_arg;
    logic         card_rsp_valid = 1'b0;
    logic [4:0]   card_rsp_len = '0;
    logic         card_rsp_err = 1'b0;
    logic [127:0] card_rsp_data = '0;

    int n_chk = 0;
    int n_fail = 0;
    logic rd_act = 1'b0;
    logic [31:0] q_exp[$];
    logic [7:0]  q_addr[$];
    string       q_tag[$];

    always #2 clk = ~clk;

    sdh_cmd_unit uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ev_set(ev_set), .irq(irq), .card_req(card_req),
        .card_idx(card_idx), .card_arg(card_arg), .card_rsp_valid(card_rsp_valid),
        .card_rsp_len(card_rsp_len), .card_rsp_err(card_rsp_err),
        .card_rsp_data(card_rsp_data)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: compares each read against the queued expectation.
    initial forever begin
        @(negedge clk);
        #1;
        if (rd_act) begin
            if (q_exp.size() == 0) begin
                chk(1'b0, "scoreboard empty", rdata, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                void'(q_addr.pop_front());
                chk(rdata === e, t, rdata, e);
            end
        end
    end

    task automatic rd_check(input logic [7:0] a, input logic [31:0] e, input string t);
        q_exp.push_back(e);
        q_addr.push_back(a);
        q_tag.push_back(t);
        @(negedge clk);
        addr = a;
        rd_act = 1'b1;
        @(negedge clk);
        rd_act = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_ev(input logic [2:0] e);
        @(negedge clk);
        ev_set = e;
        @(negedge clk);
        ev_set = '0;
    endtask

    task automatic load_rsp(input logic [4:0] len, input logic err, input logic [7:0] base);
        card_rsp_len = len;
        card_rsp_err = err;
        for (int n = 0; n < 16; n++) card_rsp_data[8*n +: 8] = base + 8'(n);
    endtask

    // Drives one command and plays the card; mid_flight exercises R3.
    task automatic run_cmd(input logic [15:0] cw, input logic [31:0] exp_arg,
                           input logic mid_flight);
        wr(8'h00, {16'h0, cw});
        chk(card_req === 1'b1, "R2 card_req raised", 32'(card_req), 32'h1);
        chk(card_idx === cw[5:0], "R2 card_idx", 32'(card_idx), 32'(cw[5:0]));
        chk(card_arg === exp_arg, "R2 card_arg", card_arg, exp_arg);
        @(negedge clk);
        chk(card_req === 1'b0, "R2 card_req one cycle", 32'(card_req), 32'h0);
        if (mid_flight) begin
            rd_check(8'h00, {16'h0, cw}, "R2 start bit set in flight");
            wr(8'h00, 32'h0000_0005);
            rd_check(8'h00, {16'h0, cw}, "R3 write in flight ignored");
        end
        @(negedge clk);
        card_rsp_valid = 1'b1;
        @(negedge clk);
        card_rsp_valid = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        chk(1'b0, "watchdog expired", 32'h0, 32'h1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(irq === 1'b0, "R1 irq after reset", 32'(irq), 32'h0);
        chk(card_req === 1'b0, "R1 card_req after reset", 32'(card_req), 32'h0);
        rd_check(8'h00, 32'h0, "R1 command reset");
        rd_check(8'h04, 32'h0, "R1 argument reset");
        rd_check(8'h10, 32'h0, "R1 response0 reset");
        rd_check(8'h1C, 32'h0, "R1 response3 reset");
        rd_check(8'h20, 32'h0, "R1 status reset");

        // R11 argument
        wr(8'h04, 32'hDEAD_BEEF);
        rd_check(8'h04, 32'hDEAD_BEEF, "R11 argument readback");

        // R5 long response, byte n = 0x10+n
        load_rsp(5'd16, 1'b0, 8'h10);
        run_cmd(16'h8202, 32'hDEAD_BEEF, 1'b0);
        rd_check(8'h00, 32'h0000_0202, "R2 start bit cleared");
        rd_check(8'h10, 32'h1C1D_1E1F, "R5 word0");
        rd_check(8'h14, 32'h1819_1A1B, "R5 word1");
        rd_check(8'h18, 32'h1415_1617, "R5 word2");
        rd_check(8'h1C, 32'h1011_1213, "R5 word3");
        rd_check(8'h20, 32'h0, "R5 no fail status");

        // R4 short response with R3 mid-flight write
        wr(8'h04, 32'h0000_1234);
        load_rsp(5'd4, 1'b0, 8'h20);
        run_cmd(16'h8011, 32'h0000_1234, 1'b1);
        rd_check(8'h00, 32'h0000_0011, "R3 command after ignored write");
        rd_check(8'h10, 32'h2021_2223, "R4 word0 big-endian");
        rd_check(8'h14, 32'h0, "R4 word1 cleared");
        rd_check(8'h18, 32'h0, "R4 word2 cleared");
        rd_check(8'h1C, 32'h0, "R4 word3 cleared");

        // R6 long requested but 4 bytes
        load_rsp(5'd4, 1'b0, 8'h40);
        run_cmd(16'h8209, 32'h0000_1234, 1'b0);
        rd_check(8'h00, 32'h0000_4209, "R6 fail bit for short-on-long");
        rd_check(8'h20, 32'h0000_0040, "R6 timeout status");
        rd_check(8'h10, 32'h2021_2223, "R6 response kept");
        chk(irq === 1'b0, "R9 timeout bit gives no irq", 32'(irq), 32'h0);
        wr(8'h20, 32'h0000_0040);
        rd_check(8'h20, 32'h0, "R8 timeout cleared");

        // R6 zero length
        load_rsp(5'd0, 1'b0, 8'h50);
        run_cmd(16'h8003, 32'h0000_1234, 1'b0);
        rd_check(8'h00, 32'h0000_4003, "R6 fail on zero length");
        // R6 odd length
        load_rsp(5'd8, 1'b0, 8'h50);
        run_cmd(16'h8004, 32'h0000_1234, 1'b0);
        rd_check(8'h00, 32'h0000_4004, "R6 fail on length 8");
        // R6 card error
        load_rsp(5'd4, 1'b1, 8'h50);
        run_cmd(16'h8005, 32'h0000_1234, 1'b0);
        rd_check(8'h00, 32'h0000_4005, "R6 fail on card error");
        rd_check(8'h10, 32'h2021_2223, "R6 response kept after error");
        wr(8'h20, 32'h0000_07FF);

        // R7 no response
        load_rsp(5'd0, 1'b0, 8'h60);
        run_cmd(16'h8400, 32'h0000_1234, 1'b0);
        rd_check(8'h00, 32'h0000_0400, "R7 no fail without response");
        rd_check(8'h10, 32'h2021_2223, "R7 response kept");
        rd_check(8'h20, 32'h0, "R7 no timeout status");
        load_rsp(5'd4, 1'b1, 8'h60);
        run_cmd(16'h8400, 32'h0000_1234, 1'b0);
        rd_check(8'h00, 32'h0000_4400, "R7 error still fails");
        wr(8'h20, 32'h0000_0040);

        // R8 / R9 status events
        pulse_ev(3'b001);
        chk(irq === 1'b1, "R9 irq on data event", 32'(irq), 32'h1);
        rd_check(8'h20, 32'h0000_0100, "R8 data event sets bit 8");
        wr(8'h20, 32'h0);
        rd_check(8'h20, 32'h0000_0100, "R8 zero write clears nothing");
        wr(8'h20, 32'h0000_0100);
        chk(irq === 1'b0, "R9 irq low after clear", 32'(irq), 32'h0);
        pulse_ev(3'b110);
        wr(8'h20, 32'h0000_0200);
        rd_check(8'h20, 32'h0000_0400, "R8 selective clear");
        chk(irq === 1'b1, "R9 irq from busy bit", 32'(irq), 32'h1);
        @(negedge clk);
        wr_en = 1'b1; addr = 8'h20; wdata = 32'h0000_0400; ev_set = 3'b100;
        @(negedge clk);
        wr_en = 1'b0; ev_set = '0;
        rd_check(8'h20, 32'h0000_0400, "R8 set wins over clear");
        wr(8'h20, 32'h0000_0400);
        rd_check(8'h20, 32'h0, "R8 all clear");

        // R10 unmapped offsets
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h24, 32'hFFFF_FFFF);
        rd_check(8'h0C, 32'h0, "R10 unmapped read 0x0C");
        rd_check(8'h24, 32'h0, "R10 unmapped read 0x24");
        rd_check(8'h00, 32'h0000_4400, "R10 command untouched");
        rd_check(8'h04, 32'h0000_1234, "R10 argument untouched");
        rd_check(8'h20, 32'h0, "R10 status untouched");
        chk(card_req === 1'b0, "R10 no request from unmapped write", 32'(card_req), 32'h0);

        repeat (3) @(negedge clk);
        chk(q_exp.size() == 0, "scoreboard drained", 32'(q_exp.size()), 32'h0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule